// File: doc/BRIEF.md
# Output Load Controller for a Multi-Channel DAC

This block decides the cycle in which each channel's output data register takes a new code. Every channel has two prepared codes, an A code and a B code. A per-channel select bit picks one of them. Each code also has a "written since last load" flag, held outside the block. A falling edge on the active-low load pin asks for a transfer. The transfer waits until the shared open-drain busy bus is released by every device on it. Only channels whose selected code was written since the previous transfer take a new value. For each channel that is transferred, the block returns a one-cycle acknowledge so the flag store can clear that one flag.

The busy bus is wired-AND across devices. This device pulls it low while its own code calculation runs. A load request that arrives while the bus is low is held and carried out once the bus goes high. If the load pin is simply held low, a transfer happens after every rising edge of the bus. The active-low clear pin switches every output buffer to its ground reference and blocks load requests. While clear is low, a held request is dropped. The output data registers keep their contents, so releasing clear brings back the previous outputs.

The sequencer has three states. `S_IDLE` goes to `S_LOAD` when a request arrives and the bus is high. It goes to `S_WAIT` when a request arrives and the bus is low. A request is either a load-pin falling edge, or a bus rising edge while the load pin is low. `S_WAIT` goes to `S_LOAD` when the bus is high, and back to `S_IDLE` when clear is active. `S_LOAD` always returns to `S_IDLE` after one cycle, and in that cycle it performs the transfer unless clear is active. The load pin, the clear pin and the bus level each pass through a two-flop synchroniser.

Top module: `dac_load_ctrl`

## Requirements
- R1: After reset every output data register is 0, `gnd_sel` is all zeros, and `ack_a` and `ack_b` are all zeros.
- R2: A falling edge on `ldac_n` while `busy_bus` is high causes a transfer within 6 clock cycles. Channel i takes `x2b` when `ab_sel[i]`=1 and `x2a` when `ab_sel[i]`=0, provided that the selected flag (`wr_b[i]` or `wr_a[i]`) is 1. Channel i occupies bits [i*DW +: DW] of the packed buses.
- R3: On a transfer, a channel whose selected flag is 0 keeps its previous value, even when its unselected flag is 1.
- R4: On a transfer, `ack_a[i]` pulses for one cycle only for a channel with `ab_sel[i]`=0 and `wr_a[i]`=1, and `ack_b[i]` pulses only for a channel with `ab_sel[i]`=1 and `wr_b[i]`=1. No other acknowledge bit is raised.
- R5: A falling edge on `ldac_n` while `busy_bus` is low changes no output register while the bus stays low. The transfer is carried out within 6 cycles after the bus goes high.
- R6: While `ldac_n` is held low, no transfer happens without a rising edge on `busy_bus`. Each rising edge causes a transfer within 6 cycles.
- R7: `busy_pull` is 1 exactly when `own_busy` is 1, which pulls the shared bus low. A transfer requested during this device's own busy time is held until the bus is released.
- R8: While `clr_n` is low, `gnd_sel` is all ones within 3 cycles and `ldac_n` edges cause no transfer and no acknowledge. The data registers keep their values. Within 3 cycles of `clr_n` going high, `gnd_sel` returns to all zeros and the outputs show the same codes as before.
- R9: A request held while the bus is low is discarded if `clr_n` goes low before the bus is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ldac_n | input | 1 | Active-low load request pin, asynchronous |
| clr_n | input | 1 | Active-low clear pin, asynchronous |
| own_busy | input | 1 | This device's code calculation is running |
| busy_bus | input | 1 | Level sensed on the shared open-drain busy bus |
| busy_pull | output | 1 | Pull-down enable for the shared busy bus |
| ab_sel | input | NCH | Per-channel code select, 1 = B |
| x2a | input | NCH*DW | Packed A codes |
| x2b | input | NCH*DW | Packed B codes |
| wr_a | input | NCH | A code written since last load |
| wr_b | input | NCH | B code written since last load |
| ack_a | output | NCH | One-cycle pulse: clear this channel's A flag |
| ack_b | output | NCH | One-cycle pulse: clear this channel's B flag |
| dac | output | NCH*DW | Packed output data registers |
| gnd_sel | output | NCH | Per-channel switch of the output buffer to ground reference |

## Verification
The transfer is swept over every combination of select bits and A and B flags on four channels, with fresh codes each round. This separates choosing the wrong code from updating a clean channel, and from clearing the wrong flag. The load request is also tried in three other ways: arriving while an external device holds the bus, held low across this device's own busy pulse, and arriving while clear is low. Together these separate an immediate transfer from a held one, an edge-triggered transfer from a level-triggered one, and a dropped request from one that survives the clear.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_WAIT = 2'd1,
        S_LOAD = 2'd2
    } dlc_state_t;
endpackage

// File: rtl/dlc_sync.sv
module dlc_sync #(
    parameter int W   = 1,
    parameter bit RV  = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= {W{RV}};
            q      <= {W{RV}};
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dlc_fsm.sv
module dlc_fsm
    import dlc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ldac_s,
    input  logic       bus_s,
    input  logic       clr_act,
    output dlc_state_t state,
    output logic       load_en
);
    dlc_state_t nxt;
    logic       ldac_d;
    logic       bus_d;
    logic       ldac_fall;
    logic       bus_rise;
    logic       request;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ldac_d <= 1'b1;
            bus_d  <= 1'b1;
        end else begin
            ldac_d <= ldac_s;
            bus_d  <= bus_s;
        end
    end

    assign ldac_fall = ldac_d & ~ldac_s;
    assign bus_rise  = ~bus_d & bus_s;
    assign request   = ldac_fall | (~ldac_s & bus_rise);

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (!clr_act && request)
                    nxt = bus_s ? S_LOAD : S_WAIT;
            end
            S_WAIT: begin
                if (clr_act)
                    nxt = S_IDLE;
                else if (bus_s)
                    nxt = S_LOAD;
            end
            S_LOAD: nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= nxt;
    end

    always_comb begin
        load_en = (state == S_LOAD) && !clr_act;
    end
endmodule

// File: rtl/dlc_bank.sv
module dlc_bank #(
    parameter int NCH = 32,
    parameter int DW  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [NCH-1:0]    ab_sel,
    input  logic [NCH*DW-1:0] x2a,
    input  logic [NCH*DW-1:0] x2b,
    input  logic [NCH-1:0]    wr_a,
    input  logic [NCH-1:0]    wr_b,
    output logic [NCH-1:0]    ack_a,
    output logic [NCH-1:0]    ack_b,
    output logic [NCH*DW-1:0] dac
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic          dirty;
        logic          take;
        logic [DW-1:0] src;
        logic [DW-1:0] hold;

        assign dirty = ab_sel[i] ? wr_b[i] : wr_a[i];
        assign src   = ab_sel[i] ? x2b[i*DW +: DW] : x2a[i*DW +: DW];
        assign take  = load_en & dirty;
        assign ack_a[i] = take & ~ab_sel[i];
        assign ack_b[i] = take &  ab_sel[i];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                hold <= '0;
            else if (take)
                hold <= src;
        end

        assign dac[i*DW +: DW] = hold;
    end
endmodule

// File: rtl/dac_load_ctrl.sv
module dac_load_ctrl
    import dlc_pkg::*;
#(
    parameter int NCH = 32,
    parameter int DW  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ldac_n,
    input  logic              clr_n,
    input  logic              own_busy,
    input  logic              busy_bus,
    output logic              busy_pull,
    input  logic [NCH-1:0]    ab_sel,
    input  logic [NCH*DW-1:0] x2a,
    input  logic [NCH*DW-1:0] x2b,
    input  logic [NCH-1:0]    wr_a,
    input  logic [NCH-1:0]    wr_b,
    output logic [NCH-1:0]    ack_a,
    output logic [NCH-1:0]    ack_b,
    output logic [NCH*DW-1:0] dac,
    output logic [NCH-1:0]    gnd_sel
);
    localparam int NPIN = 3;

    logic [NPIN-1:0] pins_s;
    logic            ldac_s;
    logic            clr_s;
    logic            bus_s;
    logic            clr_act;
    logic            load_en;
    dlc_state_t      state;

    dlc_sync #(.W(NPIN), .RV(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({busy_bus, clr_n, ldac_n}),
        .q     (pins_s)
    );

    assign ldac_s  = pins_s[0];
    assign clr_s   = pins_s[1];
    assign bus_s   = pins_s[2];
    assign clr_act = ~clr_s;

    dlc_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ldac_s  (ldac_s),
        .bus_s   (bus_s),
        .clr_act (clr_act),
        .state   (state),
        .load_en (load_en)
    );

    dlc_bank #(.NCH(NCH), .DW(DW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .ab_sel  (ab_sel),
        .x2a     (x2a),
        .x2b     (x2b),
        .wr_a    (wr_a),
        .wr_b    (wr_b),
        .ack_a   (ack_a),
        .ack_b   (ack_b),
        .dac     (dac)
    );

    assign busy_pull = own_busy;
    assign gnd_sel   = {NCH{clr_act}};
endmodule

// File: rtl/dac_load_ctrl_chk.sv
module dac_load_ctrl_chk
    import dlc_pkg::*;
#(
    parameter int NCH = 32,
    parameter int DW  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input dlc_state_t        state,
    input logic              load_en,
    input logic              bus_s,
    input logic [NCH-1:0]    wr_a,
    input logic [NCH-1:0]    wr_b,
    input logic [NCH-1:0]    ack_a,
    input logic [NCH-1:0]    ack_b,
    input logic [NCH*DW-1:0] dac,
    input logic [NCH-1:0]    gnd_sel
);
    assert_hold_unloaded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(dac));

    assert_ack_in_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack_a | ack_b) != '0) |-> (state == S_LOAD));

    assert_ack_dirty_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack_a & ~wr_a) == '0) && ((ack_b & ~wr_b) == '0));

    assert_load_after_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LOAD) |-> $past(bus_s));

    assert_clear_blocks_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gnd_sel != '0) |-> ((ack_a | ack_b) == '0));

    assert_clear_all_lanes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gnd_sel != '0) |-> (&gnd_sel));
endmodule

bind dac_load_ctrl dac_load_ctrl_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .state   (state),
    .load_en (load_en),
    .bus_s   (bus_s),
    .wr_a    (wr_a),
    .wr_b    (wr_b),
    .ack_a   (ack_a),
    .ack_b   (ack_b),
    .dac     (dac),
    .gnd_sel (gnd_sel)
);

// File: tb/dac_load_ctrl_test.sv
module dac_load_ctrl_test;
    localparam int NCH = 4;
    localparam int DW  = 8;
    localparam int VW  = NCH * DW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ldac_n = 1'b1;
    logic          clr_n = 1'b1;
    logic          own_busy = 1'b0;
    logic          ext_hold = 1'b0;
    logic          busy_bus;
    logic          busy_pull;
    logic [NCH-1:0] ab_sel = '0;
    logic [VW-1:0]  x2a = '0;
    logic [VW-1:0]  x2b = '0;
    logic [NCH-1:0] wa = '0;
    logic [NCH-1:0] wb = '0;
    logic [NCH-1:0] ack_a, ack_b;
    logic [VW-1:0]  dac;
    logic [NCH-1:0] gnd_sel;

    logic           fl_wr = 1'b0;
    logic [NCH-1:0] nwa = '0;
    logic [NCH-1:0] nwb = '0;

    logic [VW-1:0]  expv = '0;
    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    assign busy_bus = ~busy_pull & ~ext_hold;

    dac_load_ctrl #(.NCH(NCH), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .ldac_n(ldac_n), .clr_n(clr_n),
        .own_busy(own_busy), .busy_bus(busy_bus), .busy_pull(busy_pull),
        .ab_sel(ab_sel), .x2a(x2a), .x2b(x2b), .wr_a(wa), .wr_b(wb),
        .ack_a(ack_a), .ack_b(ack_b), .dac(dac), .gnd_sel(gnd_sel)
    );

    // external flag store: set by the bench, cleared by acknowledges
    always @(posedge clk) begin
        if (fl_wr) begin
            wa <= nwa;
            wb <= nwb;
        end else begin
            wa <= wa & ~ack_a;
            wb <= wb & ~ack_b;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_flags(input logic [NCH-1:0] a, input logic [NCH-1:0] b);
        nwa = a; nwb = b; fl_wr = 1'b1;
        cyc(1);
        fl_wr = 1'b0;
    endtask

    task automatic set_codes(input int k);
        for (int i = 0; i < NCH; i++) begin
            x2a[i*DW +: DW] = DW'(k * 7 + i * 13 + 1);
            x2b[i*DW +: DW] = DW'(k * 11 + i * 29 + 3);
        end
    endtask

    // expected result of one transfer with the current inputs
    task automatic model_load();
        for (int i = 0; i < NCH; i++) begin
            if (ab_sel[i] ? wb[i] : wa[i])
                expv[i*DW +: DW] = ab_sel[i] ? x2b[i*DW +: DW] : x2a[i*DW +: DW];
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [NCH-1:0] wa0, wb0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1
        chk(dac == '0, "R1 dac after reset", dac, 0);
        chk(gnd_sel == '0, "R1 gnd_sel after reset", 32'(gnd_sel), 0);
        chk((ack_a | ack_b) == '0, "R1 ack after reset", 32'(ack_a | ack_b), 0);

        // R2 R3 R4: exhaustive sweep of select and flags
        for (int s = 0; s < 16; s++) begin
            for (int fa = 0; fa < 16; fa++) begin
                for (int fb = 0; fb < 16; fb++) begin
                    ab_sel = NCH'(s);
                    set_codes(s * 256 + fa * 16 + fb);
                    set_flags(NCH'(fa), NCH'(fb));
                    cyc(1);
                    model_load();
                    ldac_n = 1'b0;
                    cyc(6);
                    chk(dac == expv, "R2 R3 transfer in sweep", dac, expv);
                    chk(wa == (NCH'(fa) & ab_sel) && wb == (NCH'(fb) & ~ab_sel),
                        "R4 flags cleared by acknowledges", {wa, wb}, {NCH'(fa) & ab_sel, NCH'(fb) & ~ab_sel});
                    ldac_n = 1'b1;
                    cyc(3);
                end
            end
        end

        // R5: request during external busy
        ab_sel = 4'b0101;
        set_codes(5000);
        set_flags(4'b1111, 4'b1111);
        ext_hold = 1'b1;
        cyc(1);
        ldac_n = 1'b0;
        cyc(2);
        ldac_n = 1'b1;
        cyc(20);
        chk(dac == expv, "R5 no transfer while bus low", dac, expv);
        model_load();
        ext_hold = 1'b0;
        cyc(6);
        chk(dac == expv, "R5 held transfer after release", dac, expv);

        // R6 R7: load pin held low across own busy pulses
        ldac_n = 1'b0;
        cyc(6);
        ab_sel = 4'b0011;
        set_codes(6000);
        set_flags(4'b1111, 4'b1111);
        cyc(10);
        chk(dac == expv, "R6 no transfer without bus edge", dac, expv);
        own_busy = 1'b1;
        cyc(1);
        chk(busy_pull == 1'b1 && busy_bus == 1'b0, "R7 own busy pulls bus", 32'(busy_pull), 1);
        cyc(8);
        chk(dac == expv, "R7 no transfer during own busy", dac, expv);
        model_load();
        own_busy = 1'b0;
        cyc(1);
        chk(busy_pull == 1'b0, "R7 bus released", 32'(busy_pull), 0);
        cyc(6);
        chk(dac == expv, "R6 transfer after bus rise", dac, expv);
        set_codes(6100);
        set_flags(4'b1111, 4'b1111);
        own_busy = 1'b1;
        cyc(5);
        model_load();
        own_busy = 1'b0;
        cyc(7);
        chk(dac == expv, "R6 second transfer after bus rise", dac, expv);
        ldac_n = 1'b1;
        cyc(4);

        // R8: clear blocks loads and keeps data
        ab_sel = 4'b1010;
        set_codes(7000);
        set_flags(4'b1111, 4'b1111);
        wa0 = wa; wb0 = wb;
        clr_n = 1'b0;
        cyc(3);
        chk(gnd_sel == '1, "R8 gnd_sel during clear", 32'(gnd_sel), 32'hF);
        ldac_n = 1'b0;
        cyc(3);
        ldac_n = 1'b1;
        cyc(6);
        chk(dac == expv, "R8 no transfer during clear", dac, expv);
        chk(wa == wa0 && wb == wb0, "R8 no acknowledge during clear", {wa, wb}, {wa0, wb0});
        clr_n = 1'b1;
        cyc(3);
        chk(gnd_sel == '0, "R8 gnd_sel after clear", 32'(gnd_sel), 0);
        chk(dac == expv, "R8 data kept after clear", dac, expv);

        // R9: clear discards a held request
        ext_hold = 1'b1;
        cyc(1);
        ldac_n = 1'b0;
        cyc(3);
        ldac_n = 1'b1;
        cyc(2);
        clr_n = 1'b0;
        cyc(4);
        clr_n = 1'b1;
        cyc(4);
        ext_hold = 1'b0;
        cyc(10);
        chk(dac == expv, "R9 held request dropped by clear", dac, expv);
        chk(wa == wa0 && wb == wb0, "R9 flags untouched", {wa, wb}, {wa0, wb0});
        model_load();
        ldac_n = 1'b0;
        cyc(6);
        chk(dac == expv, "R8 flags kept through clear", dac, expv);
        ldac_n = 1'b1;
        cyc(3);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule